// File: doc/BRIEF.md
# Overflow-Checked Integer ALU with Action Dispatch

This block executes integer add, subtract and signed divide for a scalar core. Each instruction carries two check-enable bits, one for signed overflow and one for unsigned overflow, and a 3-bit action code. The block returns the arithmetic result and an overflow flag. It also works out the next program counter from the check result. An action can jump to a handler whose address is held in a register, step over the following 2, 4 or 8 bytes of code, or bump a counter register.

Each privilege mode (user, supervisor, machine) has its own four handler addresses and one counter. An instruction uses the registers of the mode it runs in. Software writes and reads these registers through a simple port. Results appear one clock after the instruction is presented.

Top module: `ovf_alu`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 signed divide, and 3 treated as add. The result is the wrapped XLEN-bit value. A divide by zero gives all ones. The most-negative value divided by minus one gives the dividend. Both of these fixed results apply whether or not a check bit is set.
- R2: When the signed check bit is set, overflow is flagged in three cases. For add, both operands share a sign and the result sign differs. For subtract, the operand signs differ and the result sign differs from the first operand. For divide, the most-negative value is divided by minus one.
- R3: When the unsigned check bit is set, overflow is flagged on the add carry-out, on the subtract borrow (a < b unsigned), and on a divide by zero.
- R4: When both check bits are clear, the overflow flag is 0 and the next PC is PC+4, whatever the action code. No counter changes.
- R5: Action codes 0 to 3 select handler slots 0 to 3 (OS, application, library, temporary). On overflow the next PC is the address in that slot of the current mode. Otherwise the next PC is PC+4.
- R6: Action codes 4, 5 and 6 give a next PC of PC+4+2, PC+4+4 and PC+4+8 when there is no overflow. On overflow the next PC is PC+4.
- R7: Action code 7 adds one to the current mode's counter on overflow and leaves it unchanged otherwise. The next PC is always PC+4.
- R8: Register write and read use the same encoding. Mode is 0 user, 1 supervisor, 2 machine. Select values 0 to 3 are handler slots and 4 is the counter. A write changes only the addressed register of the addressed mode. Reads are combinational. If a write to a counter and an increment of that same counter happen in the same cycle, the written value wins.
- R9: The outputs are registered. out_valid is in_valid delayed by one cycle. Reset clears out_valid and all handler and counter registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_op | input | 2 | Operation code |
| in_a | input | XLEN | First operand / dividend |
| in_b | input | XLEN | Second operand / divisor |
| in_pc | input | XLEN | PC of the instruction |
| in_chk_s | input | 1 | Signed overflow check enable |
| in_chk_u | input | 1 | Unsigned overflow check enable |
| in_act | input | 3 | Action code |
| in_mode | input | 2 | Current privilege mode |
| csr_we | input | 1 | Register write enable |
| csr_wmode | input | 2 | Mode of the register to write |
| csr_wsel | input | 3 | Register select for write |
| csr_wdata | input | XLEN | Write data |
| csr_rmode | input | 2 | Mode of the register to read |
| csr_rsel | input | 3 | Register select for read |
| csr_rdata | output | XLEN | Read data |
| out_valid | output | 1 | Result valid |
| out_result | output | XLEN | Arithmetic result |
| out_ovf | output | 1 | Checked overflow occurred |
| out_next_pc | output | XLEN | Next PC after dispatch |

## Verification
A wrong flag or result shows up at out_result, out_ovf and out_next_pc one cycle after the instruction. A wrong PC shows up as a skip length or handler address that does not match. A corrupted handler or counter register stays hidden until an instruction in that mode overflows, or until the register is read back. The bench therefore reads the registers back after each counter action and after each register write, and repeats mode-specific handler calls in all three modes.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
    localparam int unsigned MODE_W   = 2;
    localparam int unsigned SLOT_CNT = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_DIV = 2'd2,
        OP_RSV = 2'd3
    } alu_op_e;

    typedef enum logic [2:0] {
        ACT_H_OS  = 3'd0,
        ACT_H_APP = 3'd1,
        ACT_H_LIB = 3'd2,
        ACT_H_TMP = 3'd3,
        ACT_SKIP2 = 3'd4,
        ACT_SKIP4 = 3'd5,
        ACT_SKIP8 = 3'd6,
        ACT_COUNT = 3'd7
    } ovf_act_e;
endpackage

// File: rtl/ovf_arith.sv
module ovf_arith #(
    parameter int unsigned XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            chk_s,
    input  logic            chk_u,
    output logic [XLEN-1:0] result,
    output logic            ovf
);
    import ovf_pkg::*;

    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic [XLEN:0]   sum_w;
    logic [XLEN:0]   dif_w;
    logic [XLEN-1:0] quot;
    logic            div_zero;
    logic            div_wrap;
    logic            sov;
    logic            uov;

    always_comb begin
        sum_w    = {1'b0, a} + {1'b0, b};
        dif_w    = {1'b0, a} - {1'b0, b};
        div_zero = (b == '0);
        div_wrap = (a == MOST_NEG) && (b == '1);
        quot     = (div_zero || div_wrap) ? '0 : XLEN'($signed(a) / $signed(b));
        unique case (alu_op_e'(op))
            OP_SUB: begin
                result = dif_w[XLEN-1:0];
                sov    = (a[XLEN-1] != b[XLEN-1]) && (result[XLEN-1] != a[XLEN-1]);
                uov    = dif_w[XLEN];
            end
            OP_DIV: begin
                result = div_zero ? '1 : (div_wrap ? a : quot);
                sov    = div_wrap;
                uov    = div_zero;
            end
            default: begin
                result = sum_w[XLEN-1:0];
                sov    = (a[XLEN-1] == b[XLEN-1]) && (result[XLEN-1] != a[XLEN-1]);
                uov    = sum_w[XLEN];
            end
        endcase
        ovf = (chk_s && sov) || (chk_u && uov);
    end
endmodule

// File: rtl/ovf_dispatch.sv
module ovf_dispatch #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [2:0]      act,
    input  logic            chk_any,
    input  logic            ovf,
    input  logic [XLEN-1:0] hnd_addr,
    output logic [XLEN-1:0] next_pc,
    output logic            count_inc
);
    import ovf_pkg::*;

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] skip_len;

    always_comb begin
        seq_pc    = pc + XLEN'(4);
        skip_len  = XLEN'(2) << (act - 3'd4);
        next_pc   = seq_pc;
        count_inc = 1'b0;
        if (chk_any) begin
            unique case (ovf_act_e'(act))
                ACT_H_OS, ACT_H_APP, ACT_H_LIB, ACT_H_TMP:
                    next_pc = ovf ? hnd_addr : seq_pc;
                ACT_SKIP2, ACT_SKIP4, ACT_SKIP8:
                    next_pc = ovf ? seq_pc : seq_pc + skip_len;
                default:
                    count_inc = ovf;
            endcase
        end
    end
endmodule

// File: rtl/ovf_csr_bank.sv
module ovf_csr_bank #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NMODES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_mode,
    input  logic [2:0]      wr_sel,
    input  logic [XLEN-1:0] wr_data,
    input  logic            inc_en,
    input  logic [1:0]      inc_mode,
    input  logic [1:0]      rd_mode,
    input  logic [2:0]      rd_sel,
    output logic [XLEN-1:0] rd_data,
    input  logic [1:0]      hnd_mode,
    input  logic [1:0]      hnd_sel,
    output logic [XLEN-1:0] hnd_addr
);
    import ovf_pkg::*;

    typedef struct packed {
        logic [SLOT_CNT-1:0][XLEN-1:0] hnd;
        logic [XLEN-1:0]               cnt;
    } bank_t;

    logic [NMODES-1:0][SLOT_CNT-1:0][XLEN-1:0] all_hnd;
    logic [NMODES-1:0][XLEN-1:0]               all_cnt;

    for (genvar m = 0; m < NMODES; m++) begin : g_mode
        bank_t bank_d;
        bank_t bank_q;

        always_comb begin
            bank_d = bank_q;
            if (inc_en && (inc_mode == MODE_W'(m))) begin
                bank_d.cnt = bank_q.cnt + XLEN'(1);
            end
            if (wr_en && (wr_mode == MODE_W'(m))) begin
                if (wr_sel < 3'd4) begin
                    bank_d.hnd[wr_sel[1:0]] = wr_data;
                end else if (wr_sel == 3'd4) begin
                    bank_d.cnt = wr_data;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q <= '0;
            end else begin
                bank_q <= bank_d;
            end
        end

        assign all_hnd[m] = bank_q.hnd;
        assign all_cnt[m] = bank_q.cnt;
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_mode) < NMODES) begin
            if (rd_sel < 3'd4) begin
                rd_data = all_hnd[rd_mode][rd_sel[1:0]];
            end else if (rd_sel == 3'd4) begin
                rd_data = all_cnt[rd_mode];
            end
        end
        hnd_addr = '0;
        if (32'(hnd_mode) < NMODES) begin
            hnd_addr = all_hnd[hnd_mode][hnd_sel];
        end
    end
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NMODES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [XLEN-1:0] in_pc,
    input  logic            in_chk_s,
    input  logic            in_chk_u,
    input  logic [2:0]      in_act,
    input  logic [1:0]      in_mode,
    input  logic            csr_we,
    input  logic [1:0]      csr_wmode,
    input  logic [2:0]      csr_wsel,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [1:0]      csr_rmode,
    input  logic [2:0]      csr_rsel,
    output logic [XLEN-1:0] csr_rdata,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic            out_ovf,
    output logic [XLEN-1:0] out_next_pc
);
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
        logic            ovf;
        logic [XLEN-1:0] npc;
    } out_t;

    out_t            out_d;
    out_t            out_q;
    logic [XLEN-1:0] alu_res;
    logic            alu_ovf;
    logic [XLEN-1:0] hnd_addr;
    logic [XLEN-1:0] disp_pc;
    logic            disp_inc;

    ovf_arith #(.XLEN(XLEN)) u_arith (
        .op     (in_op),
        .a      (in_a),
        .b      (in_b),
        .chk_s  (in_chk_s),
        .chk_u  (in_chk_u),
        .result (alu_res),
        .ovf    (alu_ovf)
    );

    ovf_dispatch #(.XLEN(XLEN)) u_disp (
        .pc        (in_pc),
        .act       (in_act),
        .chk_any   (in_chk_s | in_chk_u),
        .ovf       (alu_ovf),
        .hnd_addr  (hnd_addr),
        .next_pc   (disp_pc),
        .count_inc (disp_inc)
    );

    ovf_csr_bank #(.XLEN(XLEN), .NMODES(NMODES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_we),
        .wr_mode  (csr_wmode),
        .wr_sel   (csr_wsel),
        .wr_data  (csr_wdata),
        .inc_en   (in_valid & disp_inc),
        .inc_mode (in_mode),
        .rd_mode  (csr_rmode),
        .rd_sel   (csr_rsel),
        .rd_data  (csr_rdata),
        .hnd_mode (in_mode),
        .hnd_sel  (in_act[1:0]),
        .hnd_addr (hnd_addr)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.result = alu_res;
            out_d.ovf    = alu_ovf;
            out_d.npc    = disp_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid   = out_q.valid;
    assign out_result  = out_q.result;
    assign out_ovf     = out_q.ovf;
    assign out_next_pc = out_q.npc;
endmodule

// File: rtl/ovf_alu_chk.sv
module ovf_alu_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      in_op,
    input logic [XLEN-1:0] in_b,
    input logic [XLEN-1:0] in_pc,
    input logic            in_chk_s,
    input logic            in_chk_u,
    input logic [2:0]      in_act,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_ovf,
    input logic [XLEN-1:0] out_next_pc
);
    logic [XLEN-1:0] skip_len;
    assign skip_len = (in_act == 3'd4) ? XLEN'(2) : ((in_act == 3'd5) ? XLEN'(4) : XLEN'(8));

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_chk_s && !in_chk_u)
        |=> (!out_ovf && out_next_pc == $past(in_pc) + XLEN'(4)));

    p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_chk_s || in_chk_u) && in_act >= 3'd4 && in_act <= 3'd6)
        |=> (out_ovf ? (out_next_pc == $past(in_pc) + XLEN'(4))
                     : (out_next_pc == $past(in_pc) + XLEN'(4) + $past(skip_len))));

    p_count_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_act == 3'd7) |=> (out_next_pc == $past(in_pc) + XLEN'(4)));

    p_divzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd2 && in_b == '0) |=> (out_result == '1));
endmodule

bind ovf_alu ovf_alu_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_b        (in_b),
    .in_pc       (in_pc),
    .in_chk_s    (in_chk_s),
    .in_chk_u    (in_chk_u),
    .in_act      (in_act),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_ovf     (out_ovf),
    .out_next_pc (out_next_pc)
);

// File: tb/tb_ovf_alu.sv
module tb_ovf_alu;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      in_op = '0;
    logic [XLEN-1:0] in_a = '0, in_b = '0, in_pc = '0;
    logic            in_chk_s = 1'b0, in_chk_u = 1'b0;
    logic [2:0]      in_act = '0;
    logic [1:0]      in_mode = '0;
    logic            csr_we = 1'b0;
    logic [1:0]      csr_wmode = '0;
    logic [2:0]      csr_wsel = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [1:0]      csr_rmode = '0;
    logic [2:0]      csr_rsel = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            out_valid;
    logic [XLEN-1:0] out_result;
    logic            out_ovf;
    logic [XLEN-1:0] out_next_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [XLEN-1:0] m_hnd [3][4];
    logic [XLEN-1:0] m_cnt [3];

    ovf_alu dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [1:0] op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input bit cs, input bit cu, input logic [2:0] act, input logic [1:0] mode,
                         input logic [XLEN-1:0] pc,
                         output logic [XLEN-1:0] res, output bit ovf,
                         output logic [XLEN-1:0] npc, output bit inc);
        longint unsigned ua, ub, wide;
        bit sov, uov;
        ua = longint'(a); ub = longint'(b);
        if (op == 2'd1) begin
            res = a - b;
            sov = (a[31] != b[31]) && (res[31] != a[31]);
            uov = ua < ub;
        end else if (op == 2'd2) begin
            sov = (a == 32'h8000_0000) && (b == 32'hffff_ffff);
            uov = (b == 0);
            if (uov) res = 32'hffff_ffff;
            else if (sov) res = a;
            else res = 32'($signed(a) / $signed(b));
        end else begin
            wide = ua + ub;
            res = wide[31:0];
            sov = (a[31] == b[31]) && (res[31] != a[31]);
            uov = wide[32];
        end
        ovf = (cs && sov) || (cu && uov);
        npc = pc + 4;
        inc = 1'b0;
        if (cs || cu) begin
            if (act < 4) begin
                if (ovf) npc = m_hnd[mode][act[1:0]];
            end else if (act < 7) begin
                if (!ovf) npc = pc + 4 + (32'd2 << (act - 3'd4));
            end else begin
                inc = ovf;
            end
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input bit cs, input bit cu, input logic [2:0] act, input logic [1:0] mode,
                         input logic [XLEN-1:0] pc, input bit we = 1'b0,
                         input logic [2:0] wsel = 3'd0, input logic [XLEN-1:0] wdata = '0);
        logic [XLEN-1:0] e_res, e_npc;
        bit e_ovf, e_inc;
        string pctag;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_chk_s = cs; in_chk_u = cu;
        in_act = act; in_mode = mode; in_pc = pc;
        csr_we = we; csr_wmode = mode; csr_wsel = wsel; csr_wdata = wdata;
        model(op, a, b, cs, cu, act, mode, pc, e_res, e_ovf, e_npc, e_inc);
        @(posedge clk);
        if (e_inc) m_cnt[mode] = m_cnt[mode] + 1;
        if (we) begin
            if (wsel < 4) m_hnd[mode][wsel[1:0]] = wdata;
            else if (wsel == 4) m_cnt[mode] = wdata;
        end
        #1;
        csr_we = 1'b0;
        pctag = !(cs || cu) ? "R4" : (act < 4) ? "R5" : (act < 7) ? "R6" : "R7";
        check(out_valid === 1'b1, "R9", "out_valid", 32'(out_valid), 32'd1);
        check(out_result === e_res, "R1", "result", out_result, e_res);
        check(out_ovf === e_ovf, cs ? "R2" : "R3", "ovf", 32'(out_ovf), 32'(e_ovf));
        check(out_next_pc === e_npc, pctag, "next_pc", out_next_pc, e_npc);
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check(out_valid === 1'b0, "R9", "out_valid idle", 32'(out_valid), 32'd0);
    endtask

    task automatic csr_write(input logic [1:0] mode, input logic [2:0] sel, input logic [XLEN-1:0] data);
        @(negedge clk);
        in_valid = 1'b0;
        csr_we = 1'b1; csr_wmode = mode; csr_wsel = sel; csr_wdata = data;
        @(posedge clk);
        if (sel < 4) m_hnd[mode][sel[1:0]] = data;
        else if (sel == 4) m_cnt[mode] = data;
        #1;
        csr_we = 1'b0;
    endtask

    task automatic csr_check(input logic [1:0] mode, input logic [2:0] sel, input string tag);
        logic [XLEN-1:0] exp;
        exp = (sel < 4) ? m_hnd[mode][sel[1:0]] : m_cnt[mode];
        csr_rmode = mode; csr_rsel = sel;
        #1;
        check(csr_rdata === exp, tag, "csr read", csr_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 3; m++) begin
            m_cnt[m] = '0;
            for (int h = 0; h < 4; h++) m_hnd[m][h] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R9", "out_valid in reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R9: registers cleared by reset
        for (int m = 0; m < 3; m++) csr_check(2'(m), 3'd4, "R9");
        csr_check(2'd2, 3'd3, "R9");

        // R8: distinct handler values per mode and slot
        for (int m = 0; m < 3; m++)
            for (int h = 0; h < 4; h++)
                csr_write(2'(m), 3'(h), 32'h1000_0000 + 32'(m) * 32'h100 + 32'(h) * 32'h10);
        for (int m = 0; m < 3; m++)
            for (int h = 0; h < 4; h++) csr_check(2'(m), 3'(h), "R8");
        csr_write(2'd1, 3'd4, 32'd50);
        csr_check(2'd0, 3'd4, "R8");
        csr_check(2'd1, 3'd4, "R8");

        // R2 / R5: signed add overflow goes to handler
        issue(2'd0, 32'h7fff_ffff, 32'd1, 1, 0, 3'd0, 2'd0, 32'h400);
        // R3 / R5: carry
        issue(2'd0, 32'hffff_ffff, 32'd1, 0, 1, 3'd1, 2'd1, 32'h404);
        // R3 / R5: borrow
        issue(2'd1, 32'd0, 32'd1, 0, 1, 3'd2, 2'd2, 32'h408);
        // R2 / R5: signed subtract overflow
        issue(2'd1, 32'h8000_0000, 32'd1, 1, 0, 3'd3, 2'd0, 32'h40c);
        // R5: no overflow falls through
        issue(2'd0, 32'd5, 32'd6, 1, 1, 3'd0, 2'd2, 32'h410);
        // R3: carry not flagged when only signed check
        issue(2'd0, 32'hffff_ffff, 32'd1, 1, 0, 3'd2, 2'd1, 32'h414);
        // R6: skips with no overflow, and overflow falls through
        issue(2'd0, 32'd1, 32'd2, 1, 1, 3'd4, 2'd0, 32'h500);
        issue(2'd0, 32'd1, 32'd2, 1, 1, 3'd5, 2'd0, 32'h500);
        issue(2'd0, 32'd1, 32'd2, 1, 1, 3'd6, 2'd0, 32'h500);
        issue(2'd0, 32'h7fff_ffff, 32'd2, 1, 0, 3'd6, 2'd0, 32'h500);
        // R4: checks off, overflowing add, skip action ignored
        issue(2'd0, 32'h7fff_ffff, 32'd1, 0, 0, 3'd4, 2'd0, 32'h600);
        issue(2'd1, 32'd0, 32'd1, 0, 0, 3'd7, 2'd1, 32'h604);
        csr_check(2'd1, 3'd4, "R4");
        // R1 / R3: divide by zero
        issue(2'd2, 32'd77, 32'd0, 0, 1, 3'd1, 2'd2, 32'h700);
        issue(2'd2, 32'd77, 32'd0, 0, 0, 3'd1, 2'd2, 32'h700);
        // R1 / R2: most-negative / -1
        issue(2'd2, 32'h8000_0000, 32'hffff_ffff, 1, 0, 3'd3, 2'd1, 32'h704);
        issue(2'd2, 32'hffff_fff9, 32'd2, 1, 1, 3'd0, 2'd0, 32'h708);
        // R1: reserved op acts as add
        issue(2'd3, 32'd10, 32'd20, 0, 0, 3'd0, 2'd0, 32'h70c);
        // R7: counter increments on overflow only
        issue(2'd0, 32'hffff_ffff, 32'd3, 0, 1, 3'd7, 2'd1, 32'h800);
        csr_check(2'd1, 3'd4, "R7");
        issue(2'd0, 32'd1, 32'd3, 0, 1, 3'd7, 2'd1, 32'h804);
        csr_check(2'd1, 3'd4, "R7");
        csr_check(2'd0, 3'd4, "R7");
        // R8: same-cycle write beats increment
        issue(2'd0, 32'hffff_ffff, 32'd3, 0, 1, 3'd7, 2'd2, 32'h808, 1'b1, 3'd4, 32'd900);
        csr_check(2'd2, 3'd4, "R8");
        // R8: handler rewrite used on next overflow
        issue(2'd0, 32'hffff_ffff, 32'd3, 0, 1, 3'd0, 2'd1, 32'h80c, 1'b1, 3'd0, 32'h2222_0000);
        issue(2'd0, 32'hffff_ffff, 32'd3, 0, 1, 3'd0, 2'd1, 32'h810);
        idle_check();

        // mixed traffic compared every clock
        for (int i = 0; i < 400; i++) begin
            logic [XLEN-1:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 7 == 0) rb = 0;
            if (i % 11 == 0) begin ra = 32'h8000_0000; rb = 32'hffff_ffff; end
            if (i % 5 == 0) ra = 32'h7fff_ffff;
            issue(2'($urandom_range(0, 3)), ra, rb, 1'($urandom), 1'($urandom),
                  3'($urandom_range(0, 7)), 2'($urandom_range(0, 2)), {$urandom} & 32'hffff_fffc);
        end
        idle_check();
        for (int m = 0; m < 3; m++) csr_check(2'(m), 3'd4, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule